// File: doc/BRIEF.md
# Register Rename Unit with Free Pool

This unit sits between decode and dispatch in an out-of-order core. It translates the 32 architectural register names into 64 physical register numbers. For every incoming instruction it looks up the physical homes of two source operands. If the instruction writes a result, it takes a fresh physical register from a pool of unused ones. It also hands back the physical register that the destination was mapped to before, so the reorder buffer can keep that number until the instruction retires.

Two maps are kept. The speculative map reflects every instruction that has been renamed. The retired map reflects only instructions that have committed. At commit, the result already sits in its physical register, so no data moves. The retired map entry for the destination is pointed at the new register, and the register it displaces goes back to the pool. A flush discards all speculative work. The speculative map is reloaded from the retired map, and the pool read position is rolled back so that every register not named by the retired map becomes free again.

The rename port is a valid/ready stream. `ren_ready` depends only on internal state and on `flush`, never on `ren_valid`. A rename takes effect in a cycle where both `ren_valid` and `ren_ready` are high. The result outputs are valid in that same cycle. The upstream stage may hold `ren_valid` high while `ren_ready` is low, and nothing changes until the transfer happens. Commit and flush are plain control inputs that are always accepted.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i for i = 0..31 in both maps. The pool holds exactly physical registers 32..63, and these are handed out in ascending order.
- R2: `ren_psrc_a` and `ren_psrc_b` return the speculative mapping of `ren_lsrc_a` and `ren_lsrc_b` in the same cycle. Once a rename writes a destination, later lookups of that architectural register return the new physical register.
- R3: A rename with `ren_dst_en`=1 gives out the oldest register in the pool on `ren_pdst`, and `ren_pold` shows the destination's previous speculative mapping. Registers are handed out in the order they entered the pool.
- R4: When a source and the destination of one instruction name the same architectural register, the source returns the mapping as it stood before this instruction's allocation.
- R5: `ren_ready` is low whenever the pool is empty, and no allocation or map change happens in that state, even with `ren_valid` held high.
- R6: A rename with `ren_dst_en`=0 takes nothing from the pool and leaves the speculative map unchanged.
- R7: A commit with `cmt_valid`=1 and `cmt_dst_en`=1 sets the retired mapping of `cmt_ldst` to `cmt_pdst`. It appends the previously retired mapping of `cmt_ldst` to the tail of the pool.
- R8: A commit with `cmt_dst_en`=0 changes neither map and adds nothing to the pool.
- R9: During a cycle with `flush`=1, `ren_ready` is low. After that edge, the speculative map equals the retired map, including any commit made in the flush cycle. The pool then holds 32 registers: first the uncommitted allocations in their allocation order, then the registers that were already free, in their old order.
- R10: A rename and a commit in the same cycle both take effect. The allocation comes from the pool head as it was before the cycle, and the freed register goes to the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Unit can accept a rename this cycle |
| ren_dst_en | input | 1 | Instruction writes a destination register |
| ren_ldst | input | 5 | Architectural destination |
| ren_lsrc_a | input | 5 | Architectural source A |
| ren_lsrc_b | input | 5 | Architectural source B |
| ren_psrc_a | output | 6 | Physical register for source A |
| ren_psrc_b | output | 6 | Physical register for source B |
| ren_pdst | output | 6 | Newly allocated physical destination |
| ren_pold | output | 6 | Previous speculative mapping of the destination |
| cmt_valid | input | 1 | An instruction retires this cycle |
| cmt_dst_en | input | 1 | Retiring instruction has a destination |
| cmt_ldst | input | 5 | Architectural destination of the retiring instruction |
| cmt_pdst | input | 6 | Physical destination of the retiring instruction |
| flush | input | 1 | Discard all speculative state |

## Verification
Renaming and committing can land on the same edge. At that edge the pool is popped at its head and pushed at its tail, and both maps are written. The bench provokes this on purpose, right after the pool has been drained and refilled by one entry. It also does so throughout a long randomized phase. A scoreboard model predicts the exact order in which registers come back out. Flush is also combined with a same-cycle commit, and lookups made just afterwards are compared against the model's retired map.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int RN_LOG_REGS  = 32;
  localparam int RN_PHYS_REGS = 64;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_LOG  = rn_pkg::RN_LOG_REGS,
  parameter int NUM_PHYS = rn_pkg::RN_PHYS_REGS,
  localparam int LW = $clog2(NUM_LOG),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rd_a,
  input  logic [LW-1:0] rd_b,
  input  logic [LW-1:0] rd_d,
  output logic [PW-1:0] map_a,
  output logic [PW-1:0] map_b,
  output logic [PW-1:0] map_d,
  input  logic          spec_we,
  input  logic [LW-1:0] spec_l,
  input  logic [PW-1:0] spec_p,
  input  logic          ret_we,
  input  logic [LW-1:0] ret_l,
  input  logic [PW-1:0] ret_p,
  output logic [PW-1:0] ret_old,
  input  logic          flush
);
  logic [PW-1:0] spec_q [NUM_LOG];
  logic [PW-1:0] ret_q  [NUM_LOG];

  // reads see state before this cycle's writes
  assign map_a   = spec_q[rd_a];
  assign map_b   = spec_q[rd_b];
  assign map_d   = spec_q[rd_d];
  assign ret_old = ret_q[ret_l];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LOG; i++) begin
        spec_q[i] <= PW'(i);
        ret_q[i]  <= PW'(i);
      end
    end else begin
      if (flush) begin
        for (int i = 0; i < NUM_LOG; i++)
          spec_q[i] <= (ret_we && ret_l == LW'(i)) ? ret_p : ret_q[i];
      end else if (spec_we) begin
        spec_q[spec_l] <= spec_p;
      end
      if (ret_we) ret_q[ret_l] <= ret_p;
    end
  end

  for (genvar g = 0; g < NUM_LOG; g++) begin : g_flush_chk
    AST_FLUSH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> spec_q[g] == ret_q[g]); // R9
  end

  AST_RET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_we |=> ret_q[$past(ret_l)] == $past(ret_p)); // R7
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NUM_LOG  = rn_pkg::RN_LOG_REGS,
  parameter int NUM_PHYS = rn_pkg::RN_PHYS_REGS,
  localparam int PW    = $clog2(NUM_PHYS),
  localparam int PTRW  = PW + 1,
  localparam int SPARE = NUM_PHYS - NUM_LOG
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pop,
  input  logic            push,
  input  logic [PW-1:0]   push_reg,
  input  logic            flush,
  output logic [PW-1:0]   head,
  output logic            empty,
  output logic [PTRW-1:0] count
);
  logic [PW-1:0]   ring_q [NUM_PHYS];
  logic [PTRW-1:0] rd_q, wr_q, rd_nx, wr_nx;

  assign count = wr_q - rd_q;
  assign empty = (count == '0);
  assign head  = ring_q[rd_q[PW-1:0]];

  always_comb begin
    wr_nx = wr_q + PTRW'(push);
    // rollback: everything not held by the retired map is free again
    rd_nx = flush ? (wr_nx - PTRW'(SPARE)) : (rd_q + PTRW'(pop));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= PTRW'(SPARE);
      for (int i = 0; i < NUM_PHYS; i++)
        ring_q[i] <= (i < SPARE) ? PW'(NUM_LOG + i) : '0;
    end else begin
      rd_q <= rd_nx;
      wr_q <= wr_nx;
      if (push) ring_q[wr_q[PW-1:0]] <= push_reg;
    end
  end

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R5
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PTRW'(SPARE)); // R1
  AST_FLUSH_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == PTRW'(SPARE)); // R9
  AST_NO_POP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !pop); // R9
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
  parameter int NUM_LOG  = rn_pkg::RN_LOG_REGS,
  parameter int NUM_PHYS = rn_pkg::RN_PHYS_REGS,
  localparam int LW   = $clog2(NUM_LOG),
  localparam int PW   = $clog2(NUM_PHYS),
  localparam int PTRW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic          ren_dst_en,
  input  logic [LW-1:0] ren_ldst,
  input  logic [LW-1:0] ren_lsrc_a,
  input  logic [LW-1:0] ren_lsrc_b,
  output logic [PW-1:0] ren_psrc_a,
  output logic [PW-1:0] ren_psrc_b,
  output logic [PW-1:0] ren_pdst,
  output logic [PW-1:0] ren_pold,
  input  logic          cmt_valid,
  input  logic          cmt_dst_en,
  input  logic [LW-1:0] cmt_ldst,
  input  logic [PW-1:0] cmt_pdst,
  input  logic          flush
);
  logic            pool_empty, alloc, retire;
  logic [PW-1:0]   pool_head, freed_reg;
  logic [PTRW-1:0] pool_cnt;

  assign ren_ready = !pool_empty && !flush;
  assign alloc     = ren_valid && ren_ready && ren_dst_en;
  assign retire    = cmt_valid && cmt_dst_en;
  assign ren_pdst  = pool_head;

  rn_map_table #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_a(ren_lsrc_a), .rd_b(ren_lsrc_b), .rd_d(ren_ldst),
    .map_a(ren_psrc_a), .map_b(ren_psrc_b), .map_d(ren_pold),
    .spec_we(alloc), .spec_l(ren_ldst), .spec_p(pool_head),
    .ret_we(retire), .ret_l(cmt_ldst), .ret_p(cmt_pdst), .ret_old(freed_reg),
    .flush(flush)
  );

  rn_free_list #(.NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .pop(alloc), .push(retire), .push_reg(freed_reg), .flush(flush),
    .head(pool_head), .empty(pool_empty), .count(pool_cnt)
  );

  AST_PDST_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> ren_pdst != ren_pold); // R3
  AST_NO_DST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready && !ren_dst_en && !cmt_valid && !flush) |=> $stable(pool_cnt)); // R6
  AST_SWAP_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && retire && !flush) |=> $stable(pool_cnt)); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pool_empty && !retire && !flush) |=> pool_empty); // R5
  AST_NULL_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !cmt_dst_en && !(ren_valid && ren_ready) && !flush) |=> $stable(pool_cnt)); // R8
endmodule

// File: tb/rn_rename_unit_tb.sv
`timescale 1ns/1ps
module rn_rename_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ren_valid = 0, ren_ready, ren_dst_en = 0;
  logic [4:0] ren_ldst = 0, ren_lsrc_a = 0, ren_lsrc_b = 0;
  logic [5:0] ren_psrc_a, ren_psrc_b, ren_pdst, ren_pold;
  logic cmt_valid = 0, cmt_dst_en = 0, flush = 0;
  logic [4:0] cmt_ldst = 0;
  logic [5:0] cmt_pdst = 0;

  always #2.5 clk = ~clk;

  rn_rename_unit u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  int spec_m [32];
  int ret_m [32];
  int pool [$];
  int fl_l [$];
  int fl_p [$];
  // scoreboard
  int q_a [$], q_b [$], q_d [$], q_o [$];
  bit q_de [$];
  string q_tag [$];

  task automatic chk(input string tag, input int act, input int exp_v, input string what);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
    end
  endtask

  task automatic cyc(input bit rv, input bit de, input int ld, input int sa, input int sb,
                     input bit cv, input bit cde, input bit fl, input string tag);
    int e_l, e_p;
    bit do_ret, exp_rdy;
    @(negedge clk);
    do_ret = cv && cde && (fl_l.size() > 0);
    e_l = do_ret ? fl_l[0] : 3;
    e_p = do_ret ? fl_p[0] : 0;
    ren_valid = rv; ren_dst_en = de; ren_ldst = 5'(ld);
    ren_lsrc_a = 5'(sa); ren_lsrc_b = 5'(sb);
    cmt_valid = cv && (!cde || do_ret); cmt_dst_en = do_ret;
    cmt_ldst = 5'(e_l); cmt_pdst = 6'(e_p); flush = fl;
    #0.5;
    exp_rdy = (pool.size() > 0) && !fl;
    chk(fl ? "R9" : "R5", int'(ren_ready), int'(exp_rdy), "ready");
    if (rv && exp_rdy) begin
      q_a.push_back(spec_m[sa]); q_b.push_back(spec_m[sb]);
      q_de.push_back(de); q_tag.push_back(tag);
      if (de) begin
        int np;
        np = pool.pop_front();
        q_d.push_back(np); q_o.push_back(spec_m[ld]);
        spec_m[ld] = np;
        fl_l.push_back(ld); fl_p.push_back(np);
      end else begin
        q_d.push_back(0); q_o.push_back(0);
      end
    end
    if (do_ret) begin
      void'(fl_l.pop_front()); void'(fl_p.pop_front());
      pool.push_back(ret_m[e_l]);
      ret_m[e_l] = e_p;
    end
    if (fl) begin
      for (int i = fl_p.size() - 1; i >= 0; i--) pool.push_front(fl_p[i]);
      fl_l.delete(); fl_p.delete();
      for (int i = 0; i < 32; i++) spec_m[i] = ret_m[i];
    end
  endtask

  // monitor
  always @(negedge clk) begin
    #1;
    if (rst_n && ren_valid && ren_ready && !done) begin
      if (q_a.size() == 0) begin
        chk("R2", 1, 0, "unexpected rename");
      end else begin
        string t;
        bit de;
        int ea, eb, ed, eo;
        t = q_tag.pop_front(); de = q_de.pop_front();
        ea = q_a.pop_front(); eb = q_b.pop_front();
        ed = q_d.pop_front(); eo = q_o.pop_front();
        chk(t, int'(ren_psrc_a), ea, "psrc_a");
        chk(t, int'(ren_psrc_b), eb, "psrc_b");
        if (de) begin
          chk(t, int'(ren_pdst), ed, "pdst");
          chk(t, int'(ren_pold), eo, "pold");
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin spec_m[i] = i; ret_m[i] = i; pool.push_back(32 + i); end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset mapping and ordered pool
    cyc(1, 0, 0, 0, 31, 0, 0, 0, "R1");
    cyc(1, 1, 5, 1, 2, 0, 0, 0, "R1");
    cyc(1, 0, 0, 5, 6, 0, 0, 0, "R2");
    cyc(1, 1, 5, 5, 7, 0, 0, 0, "R4");
    cyc(1, 0, 9, 9, 5, 0, 0, 0, "R6");
    cyc(1, 1, 6, 9, 6, 0, 0, 0, "R3");
    // drain the pool
    for (int k = 0; k < 29; k++) cyc(1, 1, (k % 31) + 1, k % 32, 5, 0, 0, 0, "R3");
    cyc(1, 1, 7, 7, 7, 0, 0, 0, "R5");
    cyc(1, 0, 7, 7, 7, 0, 0, 0, "R5");
    cyc(1, 1, 7, 7, 7, 1, 0, 0, "R8");
    cyc(1, 1, 7, 7, 7, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, "R7");
    cyc(0, 0, 0, 0, 0, 1, 1, 0, "R7");
    cyc(1, 1, 9, 5, 9, 0, 0, 0, "R7");
    cyc(1, 1, 10, 10, 5, 1, 1, 0, "R10");
    cyc(1, 1, 11, 11, 10, 1, 1, 0, "R10");
    cyc(1, 1, 12, 5, 6, 1, 1, 1, "R9");
    cyc(1, 0, 0, 5, 6, 0, 0, 0, "R9");
    cyc(1, 1, 5, 9, 10, 0, 0, 0, "R9");
    cyc(1, 1, 13, 11, 12, 0, 0, 0, "R9");
    // mixed traffic
    for (int k = 0; k < 3000; k++) begin
      cyc(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 4) != 0),
          $urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31),
          bit'($urandom_range(0, 2) != 0), bit'($urandom_range(0, 5) != 0),
          bit'($urandom_range(0, 40) == 0), "R10");
    end
    @(negedge clk);
    ren_valid = 0; cmt_valid = 0; flush = 0;
    #2;
    chk("R3", q_a.size(), 0, "scoreboard residue");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule